// File: doc/BRIEF.md
# Carry-Flag Bit Manipulation Unit

This block carries out single-bit operations between a one-bit carry register and one chosen bit of a byte-wide operand. The caller presents an operation code, a bit index and an operand byte together with a valid strobe. The operand is either a register value or data that was fetched earlier. Depending on the operation, the block does one of two things. It may fold the chosen bit, or its complement, into the carry by exclusive-or. It may copy the chosen bit, or its complement, into the carry. A store form writes the carry, or its complement, into the chosen bit and returns the whole byte for write-back.

Every result is registered. A done pulse appears one clock after an operation is accepted. Store forms also raise a one-cycle write-enable beside the modified byte. A separate carry write port lets the surrounding logic set the carry directly.

Top module: `cbit_unit`

## Requirements
- R1: With `op_i` = 0 (exclusive-or form), an accepted operation sets the carry to the old carry XOR `operand_i[bit_idx_i]`, where index 0 selects the least significant bit.
- R2: With `op_i` = 1 (inverted exclusive-or form), an accepted operation sets the carry to the old carry XOR the complement of `operand_i[bit_idx_i]`.
- R3: With `op_i` = 2 (load form), an accepted operation sets the carry to `operand_i[bit_idx_i]`.
- R4: With `op_i` = 3 (inverted load form), an accepted operation sets the carry to the complement of `operand_i[bit_idx_i]`.
- R5: With `op_i` = 4 (store form), on the clock after acceptance `wb_data_o` equals `operand_i` with bit `bit_idx_i` replaced by the carry. All other bits pass through unchanged, and `wb_we_o` is high for exactly that one cycle.
- R6: With `op_i` = 5 (inverted store form), the behaviour matches R5 except that the inserted bit is the complement of the carry.
- R7: Codes 0 to 3 and the unused codes 6 and 7 never raise `wb_we_o` and leave `wb_data_o` holding its previous value.
- R8: Codes 4 to 7 leave the carry unchanged.
- R9: `done_o` is high in the cycle after each cycle in which `valid_i` is high, and low otherwise. Back-to-back operations give back-to-back done cycles, and each operation sees the carry left by the one before it.
- R10: When `c_wr_i` is high, the carry takes `c_wr_val_i` on that clock and wins over any carry update from an operation in the same cycle. A store in that same cycle inserts the carry value from before the write.
- R11: While `rst_ni` is low, `carry_o`, `done_o` and `wb_we_o` are 0 and `wb_data_o` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation accepted this cycle |
| op_i | input | 3 | Operation code (see R1 to R8) |
| bit_idx_i | input | 3 | Index of the selected operand bit |
| operand_i | input | 8 | Operand byte |
| c_wr_i | input | 1 | Direct carry write strobe |
| c_wr_val_i | input | 1 | Value for direct carry write |
| carry_o | output | 1 | Registered carry flag |
| done_o | output | 1 | Operation finished pulse |
| wb_we_o | output | 1 | Write-back enable for store forms |
| wb_data_o | output | 8 | Write-back byte |

## Verification
The main sweep drives all eight operation codes against all eight bit indices and both carry values. Each combination is tried with operands stepping through the byte range, from 0x00 up to 0xFF. This separates true from inverted forms, exposes a wrong bit selected or disturbed by an index decode fault, and catches leakage into the neighbouring bits of the write-back byte. Directed sequences then cover the cases the sweep cannot reach. These are operations issued back to back, so that the carry chains from one to the next, and a direct carry write landing in the same cycle as an exclusive-or or a store, which checks the priority and the old-carry rule.

// File: rtl/cbit_pkg.sv
package cbit_pkg;

  typedef enum logic [2:0] {
    OP_XOR  = 3'd0,
    OP_XORN = 3'd1,
    OP_LD   = 3'd2,
    OP_LDN  = 3'd3,
    OP_ST   = 3'd4,
    OP_STN  = 3'd5,
    OP_RSV6 = 3'd6,
    OP_RSV7 = 3'd7
  } cbit_op_e;

  typedef enum logic [1:0] {
    CLS_XOR  = 2'd0,
    CLS_LD   = 2'd1,
    CLS_ST   = 2'd2,
    CLS_NONE = 2'd3
  } cbit_cls_e;

  // upper two opcode bits pick the class, bit 0 picks the inverted variant
  function automatic cbit_cls_e op_class(input logic [2:0] op);
    return cbit_cls_e'(op[2:1]);
  endfunction

  function automatic logic op_inv(input logic [2:0] op);
    return op[0];
  endfunction

endpackage

// File: rtl/cbit_bit_select.sv
module cbit_bit_select #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              bit_o
);

  logic [DATA_W-1:0] hit;

  for (genvar g = 0; g < DATA_W; g++) begin : g_hit
    assign hit[g] = (idx_i == IDX_W'(g)) & data_i[g];
  end

  assign bit_o = |hit;

endmodule

// File: rtl/cbit_bit_insert.sv
module cbit_bit_insert #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o
);

  for (genvar g = 0; g < DATA_W; g++) begin : g_ins
    assign data_o[g] = (idx_i == IDX_W'(g)) ? bit_i : data_i[g];
  end

endmodule

// File: rtl/cbit_carry_alu.sv
module cbit_carry_alu
  import cbit_pkg::*;
(
  input  cbit_cls_e cls_i,
  input  logic      inv_i,
  input  logic      carry_i,
  input  logic      sel_bit_i,
  output logic      carry_nxt_o,
  output logic      carry_upd_o,
  output logic      store_o,
  output logic      store_bit_o
);

  logic sel_eff;

  assign sel_eff     = sel_bit_i ^ inv_i;
  assign store_bit_o = carry_i ^ inv_i;

  always_comb begin
    carry_nxt_o = carry_i;
    carry_upd_o = 1'b0;
    store_o     = 1'b0;
    unique case (cls_i)
      CLS_XOR: begin
        carry_nxt_o = carry_i ^ sel_eff;
        carry_upd_o = 1'b1;
      end
      CLS_LD: begin
        carry_nxt_o = sel_eff;
        carry_upd_o = 1'b1;
      end
      CLS_ST:   store_o = 1'b1;
      CLS_NONE: ;
      default:  ;
    endcase
  end

endmodule

// File: rtl/cbit_unit.sv
module cbit_unit
  import cbit_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [2:0]        op_i,
  input  logic [IDX_W-1:0]  bit_idx_i,
  input  logic [DATA_W-1:0] operand_i,
  input  logic              c_wr_i,
  input  logic              c_wr_val_i,
  output logic              carry_o,
  output logic              done_o,
  output logic              wb_we_o,
  output logic [DATA_W-1:0] wb_data_o
);

  logic              carry_q, done_q, we_q;
  logic [DATA_W-1:0] wb_q;
  logic              sel_bit;
  logic              carry_nxt, carry_upd, is_store, store_bit;
  logic [DATA_W-1:0] ins_data;
  cbit_cls_e         cls;

  assign cls = op_class(op_i);

  cbit_bit_select #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_sel (
    .data_i (operand_i),
    .idx_i  (bit_idx_i),
    .bit_o  (sel_bit)
  );

  cbit_carry_alu u_alu (
    .cls_i       (cls),
    .inv_i       (op_inv(op_i)),
    .carry_i     (carry_q),
    .sel_bit_i   (sel_bit),
    .carry_nxt_o (carry_nxt),
    .carry_upd_o (carry_upd),
    .store_o     (is_store),
    .store_bit_o (store_bit)
  );

  cbit_bit_insert #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ins (
    .data_i (operand_i),
    .idx_i  (bit_idx_i),
    .bit_i  (store_bit),
    .data_o (ins_data)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      done_q  <= 1'b0;
      we_q    <= 1'b0;
      wb_q    <= '0;
    end else begin
      done_q <= valid_i;
      we_q   <= valid_i & is_store;
      if (valid_i && is_store) wb_q <= ins_data;
      // direct write wins over an operation's carry update
      if (c_wr_i)                     carry_q <= c_wr_val_i;
      else if (valid_i && carry_upd)  carry_q <= carry_nxt;
    end
  end

  assign carry_o   = carry_q;
  assign done_o    = done_q;
  assign wb_we_o   = we_q;
  assign wb_data_o = wb_q;

endmodule

// File: rtl/cbit_unit_chk.sv
module cbit_unit_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned IDX_W  = $clog2(DATA_W)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [2:0]        op_i,
  input logic [IDX_W-1:0]  bit_idx_i,
  input logic [DATA_W-1:0] operand_i,
  input logic              c_wr_i,
  input logic              c_wr_val_i,
  input logic              carry_o,
  input logic              done_o,
  input logic              wb_we_o,
  input logic [DATA_W-1:0] wb_data_o
);

  logic [DATA_W-1:0] opnd_q;
  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] keep_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      opnd_q <= '0;
      idx_q  <= '0;
    end else begin
      opnd_q <= operand_i;
      idx_q  <= bit_idx_i;
    end
  end

  assign keep_mask = ~({{(DATA_W-1){1'b0}}, 1'b1} << idx_q);

  AST_DONE_FOLLOWS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o); // R9
  AST_NO_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o); // R9
  AST_WE_ONLY_STORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[2:1] != 2'b10) |=> !wb_we_o); // R7
  AST_WB_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[2:1] != 2'b10) |=> $stable(wb_data_o)); // R7
  AST_WB_PASSTHRU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_we_o |-> ((wb_data_o ^ opnd_q) & keep_mask) == '0); // R5
  AST_LD_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd2 && !c_wr_i) |=> carry_o == $past(operand_i[bit_idx_i])); // R3
  AST_LDN_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 3'd3 && !c_wr_i) |=> carry_o == !$past(operand_i[bit_idx_i])); // R4
  AST_ST_KEEPS_C: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i[2] && !c_wr_i) |=> $stable(carry_o)); // R8
  AST_CWR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    c_wr_i |=> carry_o == $past(c_wr_val_i)); // R10

endmodule

bind cbit_unit cbit_unit_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .bit_idx_i  (bit_idx_i),
  .operand_i  (operand_i),
  .c_wr_i     (c_wr_i),
  .c_wr_val_i (c_wr_val_i),
  .carry_o    (carry_o),
  .done_o     (done_o),
  .wb_we_o    (wb_we_o),
  .wb_data_o  (wb_data_o)
);

// File: tb/cbit_unit_tb.sv
module cbit_unit_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [2:0] bit_idx_i = '0;
  logic [7:0] operand_i = '0;
  logic       c_wr_i = 1'b0;
  logic       c_wr_val_i = 1'b0;
  logic       carry_o, done_o, wb_we_o;
  logic [7:0] wb_data_o;

  int n_total = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  logic [7:0] exp_wb = 8'h00;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  cbit_unit u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .bit_idx_i(bit_idx_i), .operand_i(operand_i), .c_wr_i(c_wr_i),
    .c_wr_val_i(c_wr_val_i), .carry_o(carry_o), .done_o(done_o),
    .wb_we_o(wb_we_o), .wb_data_o(wb_data_o)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string req_of(input int op);
    case (op)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R8";
    endcase
  endfunction

  // expected carry per R1..R4, R8
  function automatic bit model_c(input int op, input int idx, input int v, input bit cin);
    bit b = v[idx];
    bit inv = op[0];
    case (op >> 1)
      0: return cin ^ (b ^ inv);
      1: return b ^ inv;
      default: return cin;
    endcase
  endfunction

  task automatic run_op(input int op, input int idx, input int v, input bit cin);
    bit st;
    bit ec;
    logic [7:0] nb;
    @(negedge clk_i);
    // previous op has had one idle edge: R9 idle done, R5 single-cycle we
    check("R9", "done idle", int'(done_o), 0);
    check("R5", "we single", int'(wb_we_o), 0);
    c_wr_i = 1'b1; c_wr_val_i = cin;
    @(negedge clk_i);
    c_wr_i = 1'b0;
    check("R10", "carry load", int'(carry_o), int'(cin));
    valid_i = 1'b1; op_i = op[2:0]; bit_idx_i = idx[2:0]; operand_i = v[7:0];
    @(negedge clk_i);
    valid_i = 1'b0;
    st = ((op >> 1) == 2);
    ec = model_c(op, idx, v, cin);
    if (st) begin
      nb = v[7:0];
      nb[idx] = cin ^ op[0];
      exp_wb = nb;
    end
    check("R9", "done", int'(done_o), 1);
    check(req_of(op), "carry", int'(carry_o), int'(ec));
    check(st ? req_of(op) : "R7", "we", int'(wb_we_o), int'(st));
    check(st ? req_of(op) : "R7", "wb_data", int'(wb_data_o), int'(exp_wb));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R11: reset state
    check("R11", "carry rst", int'(carry_o), 0);
    check("R11", "done rst", int'(done_o), 0);
    check("R11", "we rst", int'(wb_we_o), 0);
    check("R11", "wb rst", int'(wb_data_o), 0);
    rst_ni = 1'b1;

    // sweep: all codes, indices, carries, stepped operands
    for (int op = 0; op < 8; op++)
      for (int idx = 0; idx < 8; idx++)
        for (int c = 0; c < 2; c++)
          for (int v = 0; v < 256; v += 5)
            run_op(op, idx, v, c[0]);

    // R9: back-to-back XOR ops chain the carry
    @(negedge clk_i);
    c_wr_i = 1'b1; c_wr_val_i = 1'b0;
    @(negedge clk_i);
    c_wr_i = 1'b0;
    valid_i = 1'b1; op_i = 3'd0; bit_idx_i = 3'd2; operand_i = 8'h04;
    @(negedge clk_i);
    check("R9", "b2b done1", int'(done_o), 1);
    check("R9", "b2b carry1", int'(carry_o), 1);
    op_i = 3'd0; bit_idx_i = 3'd7; operand_i = 8'h80;
    @(negedge clk_i);
    valid_i = 1'b0;
    check("R9", "b2b done2", int'(done_o), 1);
    check("R9", "b2b carry2", int'(carry_o), 0);
    @(negedge clk_i);
    check("R9", "b2b idle", int'(done_o), 0);

    // R10: direct write beats XOR in same cycle
    c_wr_i = 1'b1; c_wr_val_i = 1'b0;
    valid_i = 1'b1; op_i = 3'd0; bit_idx_i = 3'd0; operand_i = 8'h01;
    @(negedge clk_i);
    c_wr_i = 1'b0; valid_i = 1'b0;
    check("R10", "cwr priority", int'(carry_o), 0);

    // R10: store in same cycle as write uses old carry (0)
    @(negedge clk_i);
    c_wr_i = 1'b1; c_wr_val_i = 1'b1;
    valid_i = 1'b1; op_i = 3'd4; bit_idx_i = 3'd3; operand_i = 8'hFF;
    @(negedge clk_i);
    c_wr_i = 1'b0; valid_i = 1'b0;
    check("R10", "st old carry", int'(wb_data_o), 'hF7);
    check("R10", "st cwr carry", int'(carry_o), 1);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

endmodule